// File: doc/BRIEF.md
# Low-side driver fault supervisor

This block holds the digital control and diagnostic logic for one channel of a low-side power switch. It takes a control input, a shared enable and seven raw comparator flags from the analog side. From these it produces the gate-drive request, the request for the output pull-down current source, and one status bit. The status bit reports both the commanded switch state and any fault.

Each fault flag is qualified by a filter counter, and only in the channel states where that fault is meaningful. Qualified faults fall into two classes. Shutdown faults (overload, overtemperature, signal-ground loss, power-ground loss) latch and force the drive off. The latch stays set until the channel has been commanded off for a full hold interval. Warning faults (open load sensed by undervoltage, open load sensed by undercurrent, output clamp active) only invert the status. Their latch clears by itself once the condition has been absent for the same hold interval.

All times are counted in ticks of a clock-enable pulse, so the same logic serves any tick rate. The status path has an off-delay, which keeps the status level steady while the control input is pulse-width modulated.

Top module: `lsw_supervisor`

## Requirements
- R1: While `enable` is low, `gate_on` and `pulldown_en` are both 0, whatever `ctl_in` is.
- R2: With no latched fault, `gate_on` equals `enable & ctl_in` and `pulldown_en` equals `enable & ~gate_on`. The status shows the commanded state: 1 for on, 0 for off.
- R3: A qualified shutdown fault sets the shutdown latch on the next clock edge. From then on `gate_on` is 0 and the status is inverted. The shutdown faults are overload, overtemperature, signal-ground loss and power-ground loss.
- R4: The shutdown latch clears only on the clock edge where `enable & ctl_in` has been 0 for HOLD_TICKS consecutive ticks. Any shorter off period restarts this count.
- R5: A qualified warning fault sets the warning latch, which inverts the status and never forces `gate_on` low. The warning faults are open load by undervoltage, open load by undercurrent, and clamp active.
- R6: The warning latch clears on the clock edge where no warning fault has been qualified for HOLD_TICKS consecutive ticks.
- R7: A flag qualifies once it has been high for FILT_TICKS consecutive ticks while its checked state holds. Open load by undervoltage needs FILT_LONG_TICKS instead. The latch is set on the edge after that. Clamp active is not filtered and qualifies at once. A flag that drops, or a channel that leaves the checked state, restarts the count from zero.
- R8: Overload and open load by undercurrent are checked only in the on state (`enable=1, ctl_in=1`). Open load by undervoltage and clamp active are checked only in the off state (`enable=1, ctl_in=0`). Overtemperature and both ground-loss flags are checked whenever `enable=1`.
- R9: When the commanded state turns off, the status level used for the off state stays 1 for HOLD_TICKS ticks. A modulated `ctl_in` whose low phases are shorter than that therefore shows a steady 1.
- R10: A synchronous reset (`rst_n=0`) clears both latches, all filters and the off-delay. With `ctl_in` or `enable` low, the status is then 0 and `gate_on` is 0.
- R11: Filters, hold timers and the off-delay advance only on cycles with `tick=1`.
- R12: When a shutdown and a warning fault are latched together, `gate_on` is 0 and the status is inverted once, not twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base clock-enable pulse |
| ctl_in | input | 1 | Channel control input, active high |
| enable | input | 1 | Shared enable, active high |
| ovld_flag | input | 1 | Raw overload comparator flag |
| hot_flag | input | 1 | Raw overtemperature flag |
| sgnd_lost | input | 1 | Raw signal-ground loss flag |
| pgnd_lost | input | 1 | Raw power-ground loss flag |
| open_uv | input | 1 | Raw open-load flag, undervoltage sense |
| open_uc | input | 1 | Raw open-load flag, undercurrent sense |
| clamp_on | input | 1 | Raw output-clamp active flag |
| gate_on | output | 1 | Gate-drive on request |
| pulldown_en | output | 1 | Output pull-down current source enable |
| status | output | 1 | Diagnostic status bit |

## Verification
`gate_on` and `pulldown_en` follow `enable` and `ctl_in` with no delay. A fault changes the outputs on the edge after its filter count is complete, which is FILT+1 ticking edges after the flag rises (one edge for clamp). The latches clear on exactly the HOLD-th ticking edge of their quiet period, and the status off-delay ends on the HOLD-th edge as well. The bench applies inputs on the falling clock edge and samples on a later falling edge after a stated number of rising edges. It checks each boundary one edge before and one edge after it is due, so an off-by-one in any counter shows up as a mismatch.

// File: rtl/lsw_pkg.sv
// Package lsw_pkg: fault indices, check windows and class per fault for the
// low-side switch supervisor. Assumes seven raw flags in the order below.
package lsw_pkg;

    localparam int NFLT    = 7;
    localparam int F_OVLD  = 0;
    localparam int F_HOT   = 1;
    localparam int F_SGND  = 2;
    localparam int F_PGND  = 3;
    localparam int F_OPUV  = 4;
    localparam int F_OPUC  = 5;
    localparam int F_CLAMP = 6;

    // Channel state(s) in which a fault is evaluated.
    typedef enum logic [1:0] {
        WIN_ON   = 2'd0,
        WIN_OFF  = 2'd1,
        WIN_BOTH = 2'd2
    } win_e;

    // Window in which fault idx is checked.
    function automatic win_e flt_win(input int idx);
        case (idx)
            F_OVLD, F_OPUC:  return WIN_ON;
            F_OPUV, F_CLAMP: return WIN_OFF;
            default:         return WIN_BOTH;
        endcase
    endfunction

    // 1 when fault idx belongs to the shutdown class.
    function automatic bit flt_is_shutdown(input int idx);
        return (idx <= F_PGND);
    endfunction

    // Filter length in ticks; zero means the flag is used unfiltered.
    function automatic int flt_len(input int idx, input int short_len, input int long_len);
        case (idx)
            F_CLAMP: return 0;
            F_OPUV:  return long_len;
            default: return short_len;
        endcase
    endfunction

endpackage

// File: rtl/lsw_flt_filter.sv
// Module lsw_flt_filter: continuous-presence filter for one fault flag.
// det goes high once raw has been high with armed set for LEN ticks and
// drops at once with raw or armed. Assumes LEN >= 1.
module lsw_flt_filter #(
    parameter int LEN = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic armed,
    output logic det
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;
    logic          live;

    assign live = raw & armed;

    // Count ticks of uninterrupted presence, saturating at LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!live) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CW'(LEN))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign det = live && (cnt_q == CW'(LEN));

endmodule

// File: rtl/lsw_fault_latch.sv
// Module lsw_fault_latch: fault latch with a timed release. Set has priority.
// The latch clears on the edge where quiet has held for HOLD ticks in a row.
// Assumes HOLD >= 1.
module lsw_fault_latch #(
    parameter int HOLD = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic set_req,
    input  logic quiet,
    output logic latched
);

    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;
    logic          lat_q;
    logic          expire;

    assign expire = lat_q && quiet && tick && (cnt_q == CW'(HOLD - 1));

    // Latch state: set wins, timed release otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
        end else if (set_req) begin
            lat_q <= 1'b1;
        end else if (expire) begin
            lat_q <= 1'b0;
        end
    end

    // Quiet-time counter; restarts whenever quiet breaks or the latch is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!lat_q || !quiet || set_req) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign latched = lat_q;

endmodule

// File: rtl/lsw_stat_delay.sv
// Module lsw_stat_delay: off-delay on the commanded state for the status bit.
// held_on stays high HOLD ticks after cmd_on falls. Assumes HOLD >= 1.
module lsw_stat_delay #(
    parameter int HOLD = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_on,
    output logic held_on
);

    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] rem_q;

    // Reload while commanded on, count down on ticks otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (cmd_on) begin
            rem_q <= CW'(HOLD);
        end else if (tick && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign held_on = cmd_on | (rem_q != '0);

endmodule

// File: rtl/lsw_supervisor.sv
// Module lsw_supervisor: control and diagnostics for one low-side channel.
// Filters the raw flags in their checked states, sorts them into shutdown and
// warning classes, latches them, and forms gate, pull-down and status outputs.
// Assumes synchronous inputs and a single-cycle tick pulse as time base.
module lsw_supervisor #(
    parameter int HOLD_TICKS      = 1500,
    parameter int FILT_TICKS      = 18,
    parameter int FILT_LONG_TICKS = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ctl_in,
    input  logic enable,
    input  logic ovld_flag,
    input  logic hot_flag,
    input  logic sgnd_lost,
    input  logic pgnd_lost,
    input  logic open_uv,
    input  logic open_uc,
    input  logic clamp_on,
    output logic gate_on,
    output logic pulldown_en,
    output logic status
);

    import lsw_pkg::*;

    logic              on_state;
    logic              off_state;
    logic [NFLT-1:0]   raw;
    logic [NFLT-1:0]   armed;
    logic [NFLT-1:0]   det;
    logic [NFLT-1:0]   sd_bits;
    logic [NFLT-1:0]   wn_bits;
    logic              sd_any;
    logic              wn_any;
    logic              sd_lat;
    logic              wn_lat;
    logic              held_on;

    // Channel state decode.
    assign on_state  = enable & ctl_in;
    assign off_state = enable & ~ctl_in;

    assign raw = {clamp_on, open_uc, open_uv, pgnd_lost, sgnd_lost, hot_flag, ovld_flag};

    // Per-fault window, filter and class split.
    for (genvar i = 0; i < NFLT; i++) begin : g_flt
        localparam int   LEN = flt_len(i, FILT_TICKS, FILT_LONG_TICKS);
        localparam win_e WIN = flt_win(i);

        if (WIN == WIN_ON) begin : g_on
            assign armed[i] = on_state;
        end else if (WIN == WIN_OFF) begin : g_off
            assign armed[i] = off_state;
        end else begin : g_both
            assign armed[i] = enable;
        end

        if (LEN == 0) begin : g_direct
            assign det[i] = raw[i] & armed[i];
        end else begin : g_filt
            lsw_flt_filter #(.LEN(LEN)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .raw   (raw[i]),
                .armed (armed[i]),
                .det   (det[i])
            );
        end

        if (flt_is_shutdown(i)) begin : g_sd
            assign sd_bits[i] = det[i];
            assign wn_bits[i] = 1'b0;
        end else begin : g_wn
            assign sd_bits[i] = 1'b0;
            assign wn_bits[i] = det[i];
        end
    end

    assign sd_any = |sd_bits;
    assign wn_any = |wn_bits;

    // Shutdown class: released after the channel is commanded off long enough.
    lsw_fault_latch #(.HOLD(HOLD_TICKS)) u_sd_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .set_req (sd_any),
        .quiet   (~on_state),
        .latched (sd_lat)
    );

    // Warning class: released after the condition has been gone long enough.
    lsw_fault_latch #(.HOLD(HOLD_TICKS)) u_wn_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .set_req (wn_any),
        .quiet   (~wn_any),
        .latched (wn_lat)
    );

    // Status off-delay on the commanded state.
    lsw_stat_delay #(.HOLD(HOLD_TICKS)) u_stat_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmd_on  (on_state),
        .held_on (held_on)
    );

    // Output forming: shutdown gates the drive, any latch inverts status once.
    assign gate_on     = on_state & ~sd_lat;
    assign pulldown_en = enable & ~gate_on;
    assign status      = held_on ^ (sd_lat | wn_lat);

endmodule

// File: rtl/lsw_supervisor_chk.sv
// Module lsw_supervisor_chk: temporal checks on lsw_supervisor, bound to every
// instance of the top. Observes ports and the class latches only.
module lsw_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ctl_in,
    input logic gate_on,
    input logic pulldown_en,
    input logic status,
    input logic sd_lat,
    input logic wn_lat,
    input logic sd_any,
    input logic wn_any
);

    // R1: disable mode turns drive and pull-down off.
    a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!gate_on && !pulldown_en));

    // R3: the shutdown latch only rises after a qualified shutdown fault.
    a_r3_sd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_lat) |-> $past(sd_any));

    // R4: the shutdown latch only falls after a cycle commanded off.
    a_r4_sd_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_lat) |-> $past(!enable || !ctl_in));

    // R6: the warning latch only falls after a cycle with no warning fault.
    a_r6_wn_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wn_lat) |-> $past(!wn_any));

    // R9: one cycle after a fault-free on command the status is high unless a latch set.
    a_r9_status_on: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ctl_in && !sd_lat && !wn_lat) |=> (status || sd_lat || wn_lat));

endmodule

bind lsw_supervisor lsw_supervisor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .ctl_in      (ctl_in),
    .gate_on     (gate_on),
    .pulldown_en (pulldown_en),
    .status      (status),
    .sd_lat      (sd_lat),
    .wn_lat      (wn_lat),
    .sd_any      (sd_any),
    .wn_any      (wn_any)
);

// File: tb/lsw_supervisor_tb_top.sv
// Bench for lsw_supervisor: a vector table walked by one loop, then directed
// tests for short off periods, PWM, tick gating and reset.
module lsw_supervisor_tb_top;

    localparam int HOLD = 8;
    localparam int FILT = 4;
    localparam int FLNG = 10;

    localparam logic [6:0] OVL = 7'h01;
    localparam logic [6:0] HOT = 7'h02;
    localparam logic [6:0] SGL = 7'h04;
    localparam logic [6:0] PGL = 7'h08;
    localparam logic [6:0] OUV = 7'h10;
    localparam logic [6:0] OUC = 7'h20;
    localparam logic [6:0] CLP = 7'h40;
    localparam logic [6:0] NON = 7'h00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       en = 1'b0;
    logic       ctl = 1'b0;
    logic [6:0] flags = '0;
    logic       gate_on, pulldown_en, status;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsw_supervisor #(
        .HOLD_TICKS      (HOLD),
        .FILT_TICKS      (FILT),
        .FILT_LONG_TICKS (FLNG)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .ctl_in      (ctl),
        .enable      (en),
        .ovld_flag   (flags[0]),
        .hot_flag    (flags[1]),
        .sgnd_lost   (flags[2]),
        .pgnd_lost   (flags[3]),
        .open_uv     (flags[4]),
        .open_uc     (flags[5]),
        .clamp_on    (flags[6]),
        .gate_on     (gate_on),
        .pulldown_en (pulldown_en),
        .status      (status)
    );

    // Vector: {en, ctl, flags, edges, exp gate, exp pulldown, exp status, req}
    function automatic logic [23:0] mk(input logic e, input logic c, input logic [6:0] f,
                                       input int n, input logic g, input logic p,
                                       input logic s, input int r);
        return {e, c, f, 8'(n), g, p, s, 4'(r)};
    endfunction

    localparam int NV = 32;
    localparam logic [23:0] VEC [NV] = '{
        mk(0,0,NON, 2, 0,0,0, 1),   // R1 disabled after reset
        mk(1,0,NON, 2, 0,1,0, 2),   // R2 off state
        mk(1,1,NON, 2, 1,0,1, 2),   // R2 on state
        mk(0,1,NON, 1, 0,0,1, 9),   // R9 status held after disable
        mk(0,1,NON, 8, 0,0,0, 9),   // R9 off-delay expired
        mk(1,1,HOT, 4, 1,0,1, 7),   // R7 filter not yet qualified
        mk(1,1,HOT, 1, 0,1,0, 3),   // R3 shutdown latched
        mk(1,1,NON, 3, 0,1,0, 3),   // R3 latch holds with flag gone
        mk(1,0,NON, 7, 0,1,0, 4),   // R4 one tick short of release
        mk(1,0,NON, 1, 0,1,0, 4),   // R4 released, off
        mk(1,1,NON, 1, 1,0,1, 4),   // R4 drive free again
        mk(1,1,OUC, 4, 1,0,1, 7),   // R7 undercurrent not yet qualified
        mk(1,1,OUC, 1, 1,0,0, 5),   // R5 warning keeps drive on
        mk(1,1,NON, 7, 1,0,0, 6),   // R6 one tick short of release
        mk(1,1,NON, 1, 1,0,1, 6),   // R6 released
        mk(1,0,OUV,10, 0,1,0, 7),   // R7 long filter not yet qualified
        mk(1,0,OUV, 1, 0,1,1, 5),   // R5 off-state warning inverts
        mk(1,0,NON, 7, 0,1,1, 6),   // R6 still latched
        mk(1,0,NON, 1, 0,1,0, 6),   // R6 released
        mk(1,0,CLP, 1, 0,1,1, 7),   // R7 clamp unfiltered
        mk(1,0,NON, 8, 0,1,0, 6),   // R6 clamp warning released
        mk(1,1,OUV,12, 1,0,1, 8),   // R8 undervoltage ignored when on
        mk(1,0,OVL,12, 0,1,0, 8),   // R8 overload ignored when off
        mk(1,1,NON, 1, 1,0,1, 8),   // R8 no latch left behind
        mk(1,1,OVL, 3, 1,0,1, 7),   // R7 short pulse
        mk(1,1,NON, 1, 1,0,1, 7),   // R7 gap
        mk(1,1,OVL, 3, 1,0,1, 7),   // R7 filter restarted
        mk(1,1,NON, 2, 1,0,1, 7),   // R7 nothing latched
        mk(1,1,OVL|OUC, 5, 0,1,0,12), // R12 single inversion
        mk(1,1,NON, 8, 0,1,0,12),   // R12 warning gone, shutdown held
        mk(0,1,NON, 8, 0,0,0, 4),   // R4 release through enable low
        mk(1,1,NON, 1, 1,0,1, 2)    // R2 back to normal
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        edges(3);
        chk("R10", "gate_on in reset", gate_on, 1'b0);
        chk("R10", "status in reset", status, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            en    = VEC[v][23];
            ctl   = VEC[v][22];
            flags = VEC[v][21:15];
            edges(int'(VEC[v][14:7]));
            chk($sformatf("R%0d vec%0d", VEC[v][3:0], v), "gate_on", gate_on, VEC[v][6]);
            chk($sformatf("R%0d vec%0d", VEC[v][3:0], v), "pulldown_en", pulldown_en, VEC[v][5]);
            chk($sformatf("R%0d vec%0d", VEC[v][3:0], v), "status", status, VEC[v][4]);
        end

        // R4: an off period shorter than the hold does not release the latch.
        flags = SGL;
        edges(5);
        chk("R4", "gate after ground loss", gate_on, 1'b0);
        flags = NON; ctl = 1'b0;
        edges(5);
        ctl = 1'b1;
        edges(1);
        chk("R4", "gate after short off", gate_on, 1'b0);
        ctl = 1'b0;
        edges(HOLD);
        ctl = 1'b1;
        edges(1);
        chk("R4", "gate after full off", gate_on, 1'b1);

        // R9: PWM with short low phases gives a steady high status.
        for (int k = 0; k < 5; k++) begin
            ctl = 1'b1;
            edges(3);
            ctl = 1'b0;
            edges(5);
            chk("R9", "status during PWM", status, 1'b1);
        end
        edges(3);
        chk("R9", "status after PWM stops", status, 1'b0);

        // R11: without ticks the filter does not advance.
        ctl = 1'b1; tick = 1'b0; flags = PGL;
        edges(20);
        chk("R11", "gate with ticks stopped", gate_on, 1'b1);
        tick = 1'b1;
        edges(FILT);
        chk("R11", "gate at filter count", gate_on, 1'b1);
        edges(1);
        chk("R11", "gate after filter", gate_on, 1'b0);
        flags = NON; en = 1'b0;
        edges(HOLD);
        en = 1'b1;
        edges(1);
        chk("R11", "gate after release", gate_on, 1'b1);
        ctl = 1'b0; tick = 1'b0;
        edges(30);
        chk("R11", "status frozen off-delay", status, 1'b1);
        tick = 1'b1;
        edges(HOLD);
        chk("R11", "status after off-delay", status, 1'b0);

        // R10: reset clears a latched fault.
        flags = HOT;
        edges(FILT + 1);
        chk("R3", "status with off-state overtemperature", status, 1'b1);
        flags = NON; rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
        chk("R10", "status after reset", status, 1'b0);
        chk("R10", "gate after reset", gate_on, 1'b0);
        chk("R10", "pulldown after reset", pulldown_en, 1'b1);

        edges(2);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule